// File: doc/BRIEF.md
# Serial Register Port with Staged Commit

This block is a four-wire serial slave that gives a host byte-wide access to a small bank of control registers. Every transfer opens with a 16-bit command word. The word holds a read/write flag, a length code and a 13-bit register address. Data bytes follow the command. One transfer can move one, two or three bytes, or it can stream until chip select is released. Each further byte in a transfer goes to the next lower address.

A write to a data register lands in a staging copy. The copy that drives the downstream logic changes only when the host writes a commit register, and that commit moves every staged byte in one clock cycle. The host can pause chip select between whole bytes of a short transfer. Readback comes out on the shared data line by default. A mode bit can move readback to a dedicated output pin.

All serial inputs are synchronised into the block's system clock. The serial clock must be slow enough to be oversampled: each of its phases must last at least four system clocks.

Top module: `spi_reg_port`

## Requirements
- R1: A transfer begins when chip select falls while the port is idle. The first 16 bits, sampled on rising serial-clock edges MSB first, form the command: bit 15 = 1 for read and 0 for write, bits 14:13 hold the length code, and bits 12:0 hold the start address.
- R2: Length codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes. After the last byte, further serial-clock edges are ignored until chip select rises and falls again.
- R3: Length code 11 streams data bytes with no limit. The stream ends when chip select rises.
- R4: Within one transfer, each data byte after the first addresses one below the byte before it.
- R5: In a 1- to 3-byte transfer, chip select may go high on a whole-byte boundary, and the transfer then resumes at the next byte when chip select falls. Chip select going high in a streaming transfer, or in the middle of a byte, ends the transfer and discards the partial byte. A rising serial-clock edge seen in the same sample as a chip-select rise is not taken.
- R6: In bidirectional mode (the reset mode), read data appears on `sdio_o` with `sdio_oe_o` high during the data phase of a read, and `sdo_oe_o` stays low. Each output bit changes after a falling serial-clock edge, so that bit is valid at the next rising edge.
- R7: Bit 0 of register 0x000 selects unidirectional mode when set. In that mode read data appears on `sdo_o` with `sdo_oe_o` high, and `sdio_oe_o` stays low. The mode change takes effect at once, and the bit reads back at 0x000.
- R8: Data registers sit at addresses BASE_ADDR to BASE_ADDR+NUM_REGS-1. A write to one of them changes only its staged copy. `regs_o` (register i at bits 8i+7:8i) and readback both show the active copy, which does not change until a commit.
- R9: Writing a byte with bit 0 set to register 0x232 copies every staged byte to the active copy. Writing a byte with bit 0 clear has no effect.
- R10: The commit bit clears itself one cycle after it is set, so a read of 0x232 returns 0x00.
- R11: After reset, all staged and active bytes are 0, the port is in bidirectional mode and both output enables are low. An unmapped address reads as 0x00, and a write to it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Shared data line, inbound |
| sdio_o | output | 1 | Shared data line, outbound readback |
| sdio_oe_o | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Dedicated readback output |
| sdo_oe_o | output | 1 | Drive enable for the dedicated output |
| regs_o | output | NUM_REGS*8 | Active register bytes |

## Verification
The same synchronised sample can carry both the chip-select rise and the rising serial-clock edge that would complete a byte. In that case the byte capture and the end-of-transfer decision compete. The bench provokes this by raising both lines on the same system-clock edge after seven bits of a write. A commit follows, and the target register must still hold its old value. A normal transfer made afterwards must then land, which shows that the port returned to idle rather than stalling.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int ADDR_W  = 13;
  localparam int CNT_W   = 2;
  localparam int INSTR_W = 1 + CNT_W + ADDR_W;
  localparam int BCNT_W  = $clog2(INSTR_W);
  localparam int BYTE_W  = 8;

  // fixed map locations that the host software depends on
  localparam logic [ADDR_W-1:0] CFG_ADDR = 13'h000;
  localparam logic [ADDR_W-1:0] UPD_ADDR = 13'h232;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INSTR,
    ST_DATA
  } xfer_st_e;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdio_i,
  output logic cs_hi_o,
  output logic cs_fall_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic din_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   cs_sh, sclk_sh;
  logic [SYNC_STAGES-1:0] din_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sh   <= '1;
      sclk_sh <= '0;
      din_sh  <= '0;
    end else begin
      cs_sh   <= {cs_sh[LAST:0], cs_ni};
      sclk_sh <= {sclk_sh[LAST:0], sclk_i};
      din_sh  <= {din_sh[SYNC_STAGES-2:0], sdio_i};
    end
  end

  // all three lines see the same latency, so data aligns with its edge
  assign cs_hi_o     = cs_sh[LAST];
  assign cs_fall_o   = cs_sh[SYNC_STAGES] & ~cs_sh[LAST];
  assign sclk_rise_o = sclk_sh[LAST] & ~sclk_sh[SYNC_STAGES];
  assign sclk_fall_o = sclk_sh[SYNC_STAGES] & ~sclk_sh[LAST];
  assign din_o       = din_sh[LAST];
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_hi_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              din_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              out_bit_o,
  output logic              rd_act_o
);
  xfer_st_e            st_q;
  logic [BCNT_W-1:0]   bcnt_q;
  logic [INSTR_W-2:0]  sh_q;
  logic [INSTR_W-1:0]  sh_nxt;
  logic                rw_q, stream_q;
  logic [CNT_W-1:0]    left_q;
  logic [ADDR_W-1:0]   addr_q, addr_nxt;
  logic [BYTE_W-1:0]   out_q;
  logic                obit_q;
  logic                take, instr_done, byte_done, at_bound, last_byte;

  assign take       = sclk_rise_i & ~cs_hi_i;
  assign sh_nxt     = {sh_q, din_i};
  assign instr_done = (st_q == ST_INSTR) & take & (bcnt_q == BCNT_W'(INSTR_W - 1));
  assign byte_done  = (st_q == ST_DATA) & take & (bcnt_q == BCNT_W'(BYTE_W - 1));
  assign at_bound   = (bcnt_q[2:0] == 3'd0);
  assign last_byte  = ~stream_q & (left_q == CNT_W'(1));
  // R4: next byte one address lower; also feeds the read prefetch
  assign addr_nxt   = instr_done ? sh_nxt[ADDR_W-1:0] : addr_q - ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bcnt_q   <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      stream_q <= 1'b0;
      left_q   <= '0;
      addr_q   <= '0;
      out_q    <= '0;
      obit_q   <= 1'b0;
    end else if (cs_hi_i) begin
      // R5: whole-byte pause allowed only outside streaming
      if (st_q != ST_IDLE && (!at_bound || (st_q == ST_DATA && stream_q)))
        st_q <= ST_IDLE;
    end else if (st_q == ST_IDLE) begin
      if (cs_fall_i) begin
        st_q   <= ST_INSTR;
        bcnt_q <= '0;
        obit_q <= 1'b0;
      end
    end else begin
      if (take) begin
        sh_q   <= sh_nxt[INSTR_W-2:0];
        bcnt_q <= bcnt_q + BCNT_W'(1);
      end
      if (instr_done) begin
        rw_q     <= sh_nxt[INSTR_W-1];
        stream_q <= &sh_nxt[INSTR_W-2 -: CNT_W];
        left_q   <= sh_nxt[INSTR_W-2 -: CNT_W] + CNT_W'(1);
        addr_q   <= addr_nxt;
        bcnt_q   <= '0;
        out_q    <= rd_data_i;
        st_q     <= ST_DATA;
      end
      if (byte_done) begin
        addr_q <= addr_nxt;
        left_q <= left_q - CNT_W'(1);
        bcnt_q <= '0;
        out_q  <= rd_data_i;
        if (last_byte) st_q <= ST_IDLE;
      end
      if (sclk_fall_i && st_q == ST_DATA && rw_q) begin
        obit_q <= out_q[BYTE_W-1];
        out_q  <= {out_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign wr_en_o   = byte_done & ~rw_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = sh_nxt[BYTE_W-1:0];
  assign rd_addr_o = addr_nxt;
  assign out_bit_o = obit_q;
  assign rd_act_o  = (st_q == ST_DATA) & rw_q & ~cs_hi_i;
endmodule

// File: rtl/spi_port_bank.sv
module spi_port_bank
  import spi_port_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BASE_ADDR = 'h010
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic                       uni_o,
  output logic                       commit_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic uni_q, upd_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(BASE_ADDR + i);
    logic [BYTE_W-1:0] stage_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        act_q   <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == REG_A) stage_q <= wr_data_i;
        if (upd_q) act_q <= stage_q;
      end
    end
    assign regs_o[i*BYTE_W +: BYTE_W] = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uni_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == CFG_ADDR) uni_q <= wr_data_i[0];
      // R10: pulse lasts one cycle, during which the copy occurs
      upd_q <= wr_en_i && wr_addr_i == UPD_ADDR && wr_data_i[0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CFG_ADDR) rd_data_o = {{(BYTE_W-1){1'b0}}, uni_q};
    if (rd_addr_i == UPD_ADDR) rd_data_o = {{(BYTE_W-1){1'b0}}, upd_q};
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == ADDR_W'(BASE_ADDR + i)) rd_data_o = regs_o[i*BYTE_W +: BYTE_W];
  end

  assign uni_o    = uni_q;
  assign commit_o = upd_q;
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_port_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int BASE_ADDR   = 'h010,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic              cs_hi, cs_fall, sclk_rise, sclk_fall, din;
  logic              wr_en, out_bit, rd_act, uni, commit;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  spi_port_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdio_i,
    .cs_hi_o(cs_hi), .cs_fall_o(cs_fall), .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall), .din_o(din)
  );

  spi_port_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .cs_hi_i(cs_hi), .cs_fall_i(cs_fall), .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall), .din_i(din), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .out_bit_o(out_bit), .rd_act_o(rd_act)
  );

  spi_port_bank #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .uni_o(uni),
    .commit_o(commit), .regs_o(regs_o)
  );

  // R6/R7 readback steering
  assign sdio_oe_o = rd_act & ~uni;
  assign sdo_oe_o  = rd_act & uni;
  assign sdio_o    = sdio_oe_o & out_bit;
  assign sdo_o     = sdo_oe_o & out_bit;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
  parameter int REGS_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_hi_i,
  input logic              sclk_rise_i,
  input logic              wr_en_i,
  input logic              commit_i,
  input logic              sdio_oe_i,
  input logic              sdo_oe_i,
  input logic [REGS_W-1:0] regs_i
);
  // R6
  oe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_i && sdo_oe_i));

  // R5
  cs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |-> (!sdio_oe_i && !sdo_oe_i));

  // R1
  wr_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (sclk_rise_i && !cs_hi_i));

  // R10
  commit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !commit_i);

  // R8
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(regs_i));
endmodule

bind spi_reg_port spi_reg_port_chk #(.REGS_W(NUM_REGS*8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_hi_i(cs_hi), .sclk_rise_i(sclk_rise),
  .wr_en_i(wr_en), .commit_i(commit), .sdio_oe_i(sdio_oe_o),
  .sdo_oe_i(sdo_oe_o), .regs_i(regs_o)
);

// File: tb/spi_reg_port_bench.sv
`timescale 1ns/1ps
module spi_reg_port_bench;
  localparam int NUM_REGS = 8;
  localparam int BASE     = 'h010;
  localparam int HP       = 6;
  localparam logic [12:0] UPD = 13'h232;

  // {addr, length code, byte0, byte1, byte2}
  localparam logic [38:0] VEC [0:3] = '{
    {13'h011, 2'b00, 8'hA5, 8'h00, 8'h00},
    {13'h013, 2'b01, 8'h3C, 8'hC3, 8'h00},
    {13'h017, 2'b10, 8'h11, 8'h22, 8'h33},
    {13'h012, 2'b01, 8'h5A, 8'h69, 8'h00}
  };

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sclk_i = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe_o, sdo_o, sdo_oe_o;
  logic [NUM_REGS*8-1:0] regs_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_buf [NUM_REGS];
  logic [7:0] exp_act [NUM_REGS];
  logic [7:0] wdat [8];
  logic [7:0] rdat [8];
  logic uni_m = 1'b0, chk_oe = 1'b0, oe_ok = 1'b1;

  spi_reg_port u_spi_reg_port (
    .clk_i(clk), .rst_ni, .cs_ni, .sclk_i, .sdio_i,
    .sdio_o, .sdio_oe_o, .sdo_o, .sdo_oe_o, .regs_o
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_vec();
    logic [63:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*8 +: 8] = exp_act[i];
    return v;
  endfunction

  task automatic spi_bit(input logic b, output logic r);
    sdio_i = b;
    repeat (HP) @(negedge clk);
    r = uni_m ? sdo_o : sdio_o;
    if (chk_oe && (uni_m ? (!sdo_oe_o || sdio_oe_o) : (!sdio_oe_o || sdo_oe_o))) oe_ok = 1'b0;
    sclk_i = 1'b1;
    repeat (HP) @(negedge clk);
    sclk_i = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] w, output logic [7:0] r);
    for (int k = 7; k >= 0; k--) spi_bit(w[k], r[k]);
  endtask

  task automatic cs_on();
    cs_ni = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HP) @(negedge clk);
    cs_ni = 1'b1;
    repeat (2*HP) @(negedge clk);
  endtask

  task automatic send_ins(input logic rd, input logic [1:0] code, input logic [12:0] addr);
    logic [15:0] ins;
    logic [7:0] d;
    ins = {rd, code, addr};
    chk_oe = 1'b0;
    spi_byte(ins[15:8], d);
    spi_byte(ins[7:0], d);
  endtask

  task automatic spi_xfer(input logic rd, input logic [1:0] code, input logic [12:0] addr, input int n);
    cs_on();
    send_ins(rd, code, addr);
    chk_oe = rd;
    oe_ok  = 1'b1;
    for (int k = 0; k < n; k++) spi_byte(rd ? 8'h00 : wdat[k], rdat[k]);
    chk_oe = 1'b0;
    cs_off();
  endtask

  task automatic mdl_write(input logic [12:0] addr, input int n);
    for (int k = 0; k < n; k++) begin
      int a;
      a = int'(addr) - k - BASE;
      if (a >= 0 && a < NUM_REGS) exp_buf[a] = wdat[k];
    end
  endtask

  task automatic commit();
    wdat[0] = 8'h01;
    spi_xfer(1'b0, 2'b00, UPD, 1);
    for (int i = 0; i < NUM_REGS; i++) exp_act[i] = exp_buf[i];
  endtask

  initial begin
    wait (cyc >= 150000);
    n_fail++;
    $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic dmy;
    for (int i = 0; i < NUM_REGS; i++) begin exp_buf[i] = '0; exp_act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk(regs_o == '0, "R11 regs after reset", 64'(regs_o), 64'(0));
    chk(!sdio_oe_o && !sdo_oe_o, "R11 enables after reset",
        64'({sdio_oe_o, sdo_oe_o}), 64'(0));
    spi_xfer(1'b1, 2'b00, 13'(BASE), 1);
    chk(rdat[0] == 8'h00, "R11 reset readback", 64'(rdat[0]), 64'(0));
    chk(oe_ok, "R6 shared-line drive during read", 64'(oe_ok), 64'(1));

    // table: write, check hold, commit, read back
    for (int v = 0; v < 4; v++) begin
      logic [12:0] a;
      logic [1:0]  c;
      int n;
      a = VEC[v][38:26];
      c = VEC[v][25:24];
      n = int'(c) + 1;
      wdat[0] = VEC[v][23:16];
      wdat[1] = VEC[v][15:8];
      wdat[2] = VEC[v][7:0];
      spi_xfer(1'b0, c, a, n);
      mdl_write(a, n);
      chk(regs_o == exp_vec(), "R8 active held before commit", 64'(regs_o), exp_vec());
      commit();
      chk(regs_o == exp_vec(), "R9 commit copies staged bytes", 64'(regs_o), exp_vec());
      spi_xfer(1'b1, c, a, n);
      for (int k = 0; k < n; k++)
        chk(rdat[k] == exp_act[int'(a) - k - BASE], "R1 R2 R4 readback by length code",
            64'(rdat[k]), 64'(exp_act[int'(a) - k - BASE]));
    end

    // R9 zero commit has no effect; R10 commit reads 0
    wdat[0] = 8'h77;
    spi_xfer(1'b0, 2'b00, 13'(BASE), 1);
    mdl_write(13'(BASE), 1);
    wdat[0] = 8'h00;
    spi_xfer(1'b0, 2'b00, UPD, 1);
    chk(regs_o == exp_vec(), "R9 zero commit ignored", 64'(regs_o), exp_vec());
    spi_xfer(1'b1, 2'b00, UPD, 1);
    chk(rdat[0] == 8'h00, "R10 commit reads back zero", 64'(rdat[0]), 64'(0));
    commit();
    chk(regs_o == exp_vec(), "R9 commit after zero write", 64'(regs_o), exp_vec());
    spi_xfer(1'b1, 2'b00, UPD, 1);
    chk(rdat[0] == 8'h00, "R10 self-clear after commit", 64'(rdat[0]), 64'(0));

    // R5 stall between bytes
    cs_on();
    send_ins(1'b0, 2'b01, 13'h015);
    spi_byte(8'hE1, rdat[0]);
    repeat (HP) @(negedge clk);
    cs_ni = 1'b1;
    repeat (2*HP) @(negedge clk);
    cs_on();
    spi_byte(8'hE2, rdat[0]);
    cs_off();
    wdat[0] = 8'hE1; wdat[1] = 8'hE2;
    mdl_write(13'h015, 2);
    commit();
    chk(regs_o == exp_vec(), "R5 stalled two-byte write", 64'(regs_o), exp_vec());

    // R3 streaming write and read
    for (int k = 0; k < 5; k++) wdat[k] = 8'hF0 + 8'(k);
    spi_xfer(1'b0, 2'b11, 13'h017, 5);
    mdl_write(13'h017, 5);
    commit();
    chk(regs_o == exp_vec(), "R3 streaming write", 64'(regs_o), exp_vec());
    spi_xfer(1'b1, 2'b11, 13'h017, 5);
    for (int k = 0; k < 5; k++)
      chk(rdat[k] == exp_act[7 - k], "R3 streaming read", 64'(rdat[k]), 64'(exp_act[7 - k]));

    // R5 abort mid-byte
    cs_on();
    send_ins(1'b0, 2'b00, 13'(BASE));
    for (int k = 0; k < 4; k++) spi_bit(1'b1, dmy);
    cs_off();
    // R5 chip-select rise coincides with the completing edge
    cs_on();
    send_ins(1'b0, 2'b00, 13'h011);
    for (int k = 0; k < 7; k++) spi_bit(1'b1, dmy);
    sdio_i = 1'b1;
    repeat (HP) @(negedge clk);
    sclk_i = 1'b1;
    cs_ni  = 1'b1;
    repeat (HP) @(negedge clk);
    sclk_i = 1'b0;
    repeat (2*HP) @(negedge clk);
    commit();
    chk(regs_o == exp_vec(), "R5 partial bytes discarded", 64'(regs_o), exp_vec());
    wdat[0] = 8'h42;
    spi_xfer(1'b0, 2'b00, 13'h011, 1);
    mdl_write(13'h011, 1);
    commit();
    chk(regs_o == exp_vec(), "R5 port recovers after abort", 64'(regs_o), exp_vec());

    // R2 bytes beyond the length code are ignored
    cs_on();
    send_ins(1'b0, 2'b00, 13'h016);
    spi_byte(8'hAB, rdat[0]);
    spi_byte(8'hCD, rdat[0]);
    cs_off();
    wdat[0] = 8'hAB;
    mdl_write(13'h016, 1);
    commit();
    chk(regs_o == exp_vec(), "R2 extra byte ignored", 64'(regs_o), exp_vec());

    // R7 unidirectional mode
    wdat[0] = 8'h01;
    spi_xfer(1'b0, 2'b00, 13'h000, 1);
    uni_m = 1'b1;
    spi_xfer(1'b1, 2'b00, 13'h000, 1);
    chk(rdat[0] == 8'h01, "R7 mode bit readback", 64'(rdat[0]), 64'(1));
    chk(oe_ok, "R7 dedicated pin drives, shared line quiet", 64'(oe_ok), 64'(1));
    spi_xfer(1'b1, 2'b00, 13'h012, 1);
    chk(rdat[0] == exp_act[2], "R7 register read on dedicated pin", 64'(rdat[0]), 64'(exp_act[2]));
    wdat[0] = 8'h00;
    spi_xfer(1'b0, 2'b00, 13'h000, 1);
    uni_m = 1'b0;
    spi_xfer(1'b1, 2'b00, 13'h012, 1);
    chk(rdat[0] == exp_act[2], "R6 bidirectional read restored", 64'(rdat[0]), 64'(exp_act[2]));
    chk(oe_ok, "R6 shared-line drive restored", 64'(oe_ok), 64'(1));

    // R11 unmapped address
    wdat[0] = 8'h55;
    spi_xfer(1'b0, 2'b00, 13'h100, 1);
    spi_xfer(1'b1, 2'b00, 13'h100, 1);
    chk(rdat[0] == 8'h00, "R11 unmapped reads zero", 64'(rdat[0]), 64'(0));
    commit();
    chk(regs_o == exp_vec(), "R11 unmapped write ignored", 64'(regs_o), exp_vec());
    chk(!sdio_oe_o && !sdo_oe_o, "R6 enables low when idle",
        64'({sdio_oe_o, sdo_oe_o}), 64'(0));

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule